// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This engine walks a chain of transmit descriptors held in memory and turns each one into a stream of frame bytes. Software writes a descriptor address into the low queue-pointer register, arms the queue by writing the high pointer register with its top bit set, and enables the engine through a control register. The engine then reads the descriptor through a simple word-wide memory port. It checks that hardware owns the descriptor, streams the referenced buffer one byte per accepted beat, and writes a completion word back into the descriptor's config/status slot.

A descriptor is eight little-endian 32-bit words on a 32-byte boundary. Word 0 holds the buffer address, word 2 the next-descriptor address and word 3 the chain-end flag. Word 4 carries the byte count in its low half and a VLAN tag in its upper half. Word 5 is the config/status word. The pad and CRC requests in the config word are only passed along as sideband flags next to the byte stream. The frame logic downstream acts on them.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset, `q_valid`, `eoq`, `mem_req` and `tx_valid` are all low.
- R2: A write to the high pointer sets `q_valid` only when data bit 31 is 1. The engine leaves idle only while `q_valid` is set, control bit 15 (go) is 1 and control bit 0 (queue 0 enable) is 1. The first descriptor address is the low pointer with bits [4:0] forced to zero.
- R3: The engine reads descriptor words 0 to 5 in order at byte offsets 0, 4, 8, 12, 16 and 20. Word 0 is the buffer address, word 2 the next address, bit 31 of word 3 the chain-end flag, word 4 bits [15:0] the byte count, and word 5 the config word.
- R4: If config bit 31 (owner) is clear, the engine emits no byte and performs no write. It sets `eoq`, clears `q_valid` and returns to idle. `eoq` clears when a new high-pointer write sets `q_valid`.
- R5: The engine emits exactly byte-count bytes. Byte i is taken from the memory word at address (buf+i) rounded down to a multiple of 4, from bits [8k+7:8k] where k = (buf+i) mod 4. Any buffer alignment is accepted.
- R6: `tx_sof` is high on the first byte if config bit 1 is set. `tx_eof` is high on the last byte if config bit 0 is set. `tx_crc` follows config bit 5 and `tx_pad` follows config bit 4 on every byte.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R8: After the last byte, the engine writes the config word back to descriptor offset 20 with these changes: bit 31 cleared, bit 30 set, bits 26, 25, 24 and 19:16 cleared. All other bits are kept.
- R9: After the write-back, the engine fetches the descriptor at the next address (bits [4:0] zeroed) if the chain-end flag is clear. If the flag is set, it goes idle and clears `q_valid`.
- R10: A descriptor with byte count 0 emits no byte but is still written back and chained.
- R11: Writes to the low or high pointer while the engine is busy are ignored.
- R12: A memory request keeps its address, direction and write data unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wdata | input | 32 | Register write data |
| ptr_lo_we | input | 1 | Write low queue pointer |
| ptr_hi_we | input | 1 | Write high queue pointer (bit 31 arms) |
| ctl_we | input | 1 | Write control (bit 15 go, bits 3:0 queue enables) |
| q_valid | output | 1 | Queue pointer valid |
| eoq | output | 1 | Stopped on a descriptor not owned by hardware |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts request; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Byte accepted |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| tx_crc | output | 1 | CRC append requested |
| tx_pad | output | 1 | Padding requested |

## Verification
The bench builds the engine with `ADDR_W = 16` and the default `CNT_W = 16`. This lets a 1 KiB word memory model hold every descriptor and buffer. The reduced address width still leaves room for unaligned buffer starts, chained descriptors at separate 32-byte slots, and a pointer written with low bits set. The memory model can insert a wait cycle on every other request, and the consumer can hold off the stream, so the engine's hold behaviour on both interfaces is exercised.

// File: rtl/tdd_pkg.sv
package tdd_pkg;
  localparam int WORD_W = 32;

  // descriptor word indices
  localparam logic [2:0] WI_BUF  = 3'd0;
  localparam logic [2:0] WI_NXT  = 3'd2;
  localparam logic [2:0] WI_NXTH = 3'd3;
  localparam logic [2:0] WI_LEN  = 3'd4;
  localparam logic [2:0] WI_CFG  = 3'd5;

  // config/status bit positions
  localparam int B_EOF  = 0;
  localparam int B_SOF  = 1;
  localparam int B_PAD  = 4;
  localparam int B_CRC  = 5;
  localparam int B_LATE = 24;
  localparam int B_UNDR = 25;
  localparam int B_RLIM = 26;
  localparam int B_OK   = 30;
  localparam int B_OWN  = 31;
  localparam int B_LAST = 31;
  localparam int B_ARM  = 31;
  localparam int B_GO   = 15;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DREAD, S_EMIT, S_WBACK} dstate_e;

  function automatic logic [WORD_W-1:0] done_word(input logic [WORD_W-1:0] cfg);
    logic [WORD_W-1:0] w;
    w         = cfg;
    w[B_OWN]  = 1'b0;
    w[B_OK]   = 1'b1;
    w[B_LATE] = 1'b0;
    w[B_UNDR] = 1'b0;
    w[B_RLIM] = 1'b0;
    w[19:16]  = 4'h0;
    return w;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [WORD_W-1:0] w, input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [4:0] word_off(input logic [2:0] idx);
    return {idx, 2'b00};
  endfunction
endpackage

// File: rtl/tdd_regs.sv
module tdd_regs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       wdata,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              ctl_we,
  input  logic              busy,
  input  logic              clr_valid,
  input  logic              set_eoq,
  output logic [ADDR_W-1:0] ptr_lo,
  output logic              q_valid,
  output logic              eoq,
  output logic              go,
  output logic [3:0]        qen
);
  import tdd_pkg::*;

  logic arm_ok;
  assign arm_ok = hi_we && !busy && wdata[B_ARM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo  <= '0;
      q_valid <= 1'b0;
      eoq     <= 1'b0;
      go      <= 1'b0;
      qen     <= 4'h0;
    end else begin
      if (lo_we && !busy) ptr_lo <= wdata[ADDR_W-1:0];
      if (arm_ok) begin
        q_valid <= 1'b1;
        eoq     <= 1'b0;
      end else if (clr_valid) begin
        q_valid <= 1'b0;
      end
      if (set_eoq) eoq <= 1'b1;
      if (ctl_we) begin
        go  <= wdata[B_GO];
        qen <= wdata[3:0];
      end
    end
  end

  assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lo_we) |=> $stable(ptr_lo));
  assert_arm_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |-> $past(hi_we && wdata[B_ARM]));
endmodule

// File: rtl/tdd_walker.sv
module tdd_walker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  len,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic              last_beat,
  output logic              word_end
);
  logic [CNT_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      rem <= '0;
    end else if (load) begin
      ptr <= base;
      rem <= len;
    end else if (adv) begin
      ptr <= ptr + ADDR_W'(1);
      rem <= rem - CNT_W'(1);
    end
  end

  assign last_beat = (rem == CNT_W'(1));
  assign word_end  = &ptr[1:0];

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (rem != '0));
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       reg_wdata,
  input  logic              ptr_lo_we,
  input  logic              ptr_hi_we,
  input  logic              ctl_we,
  output logic              q_valid,
  output logic              eoq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_crc,
  output logic              tx_pad
);
  import tdd_pkg::*;

  localparam int ALIGN_B = 5;

  dstate_e           st;
  logic [ADDR_W-1:0] desc_base, buf_lo, nxt_lo, ptr_lo, w_ptr;
  logic [2:0]        widx;
  logic              last_q, first_q, go;
  logic [CNT_W-1:0]  len_q;
  logic [31:0]       cfg_q, data_q;
  logic [3:0]        qen;
  logic              last_beat, word_end;

  // named internal events
  logic busy, start, fetch_ack, desc_done, own_ok, beat, wb_ack;
  logic chain_end, halt_noown, clr_valid, walk_load;

  assign busy       = (st != S_IDLE);
  assign start      = (st == S_IDLE) && q_valid && go && qen[0];
  assign fetch_ack  = (st == S_FETCH) && mem_ack;
  assign desc_done  = fetch_ack && (widx == WI_CFG);
  assign own_ok     = mem_rdata[B_OWN];
  assign beat       = tx_valid && tx_ready;
  assign wb_ack     = (st == S_WBACK) && mem_ack;
  assign chain_end  = wb_ack && last_q;
  assign halt_noown = desc_done && !own_ok;
  assign clr_valid  = chain_end || halt_noown;
  assign walk_load  = desc_done && own_ok;

  tdd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata),
    .lo_we(ptr_lo_we), .hi_we(ptr_hi_we), .ctl_we(ctl_we),
    .busy(busy), .clr_valid(clr_valid), .set_eoq(halt_noown),
    .ptr_lo(ptr_lo), .q_valid(q_valid), .eoq(eoq), .go(go), .qen(qen)
  );

  tdd_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(walk_load), .base(buf_lo), .len(len_q),
    .adv(beat), .ptr(w_ptr), .last_beat(last_beat), .word_end(word_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      desc_base <= '0;
      widx      <= '0;
      buf_lo    <= '0;
      nxt_lo    <= '0;
      last_q    <= 1'b0;
      len_q     <= '0;
      cfg_q     <= '0;
      data_q    <= '0;
      first_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          desc_base <= {ptr_lo[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
          widx      <= '0;
          st        <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (widx)
            WI_BUF:  buf_lo <= mem_rdata[ADDR_W-1:0];
            WI_NXT:  nxt_lo <= mem_rdata[ADDR_W-1:0];
            WI_NXTH: last_q <= mem_rdata[B_LAST];
            WI_LEN:  len_q  <= mem_rdata[CNT_W-1:0];
            WI_CFG:  cfg_q  <= mem_rdata;
            default: ;
          endcase
          widx <= widx + 3'd1;
          if (widx == WI_CFG) begin
            first_q <= 1'b1;
            if (!own_ok)            st <= S_IDLE;
            else if (len_q == '0)   st <= S_WBACK;
            else                    st <= S_DREAD;
          end
        end
        S_DREAD: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= S_EMIT;
        end
        S_EMIT: if (beat) begin
          first_q <= 1'b0;
          if (last_beat)     st <= S_WBACK;
          else if (word_end) st <= S_DREAD;
        end
        S_WBACK: if (mem_ack) begin
          if (last_q) st <= S_IDLE;
          else begin
            desc_base <= {nxt_lo[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
            widx      <= '0;
            st        <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = (st == S_FETCH) || (st == S_DREAD) || (st == S_WBACK);
    mem_we   = (st == S_WBACK);
    mem_addr = '0;
    case (st)
      S_FETCH: mem_addr = desc_base + ADDR_W'(word_off(widx));
      S_DREAD: mem_addr = {w_ptr[ADDR_W-1:2], 2'b00};
      S_WBACK: mem_addr = desc_base + ADDR_W'(word_off(WI_CFG));
      default: mem_addr = '0;
    endcase
  end

  assign mem_wdata = done_word(cfg_q);
  assign tx_valid  = (st == S_EMIT);
  assign tx_data   = lane_byte(data_q, w_ptr[1:0]);
  assign tx_sof    = tx_valid && first_q && cfg_q[B_SOF];
  assign tx_eof    = tx_valid && last_beat && cfg_q[B_EOF];
  assign tx_crc    = tx_valid && cfg_q[B_CRC];
  assign tx_pad    = tx_valid && cfg_q[B_PAD];

  logic unused_bits;
  assign unused_bits = ^{qen[3:1], ptr_lo[ALIGN_B-1:0], nxt_lo[ALIGN_B-1:0]};

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_wb_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[B_OWN] && mem_wdata[B_OK]));
  assert_eoq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoq) |-> $past(mem_ack && !mem_rdata[B_OWN] && !mem_we));
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_valid) |-> $past(mem_ack));
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> !tx_valid);
endmodule

// File: tb/test_tx_desc_dma.sv
module test_tx_desc_dma;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic ptr_lo_we = 1'b0, ptr_hi_we = 1'b0, ctl_we = 1'b0;
  logic q_valid, eoq, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_sof, tx_eof, tx_crc, tx_pad;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;

  tx_desc_dma #(.ADDR_W(ADDR_W)) i_tx_desc_dma (
    .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata),
    .ptr_lo_we(ptr_lo_we), .ptr_hi_we(ptr_hi_we), .ctl_we(ctl_we),
    .q_valid(q_valid), .eoq(eoq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof),
    .tx_crc(tx_crc), .tx_pad(tx_pad)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [0:255];
  logic [11:0] exp_q [$];
  int total = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, beats = 0, r7_bad = 0, r12_bad = 0;
  int last_desc_rd = -1;
  bit stall_mode = 0, rdy_mode = 0, finished = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] expect_wb(input logic [31:0] cfg);
    return (cfg & ~32'h8700_0000 & ~32'h000F_0000) | 32'h4000_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // driver: build a descriptor and push expected bytes
  task automatic build_desc(input int at, input int bufa, input int cnt, input logic [31:0] cfg,
                            input int nxt, input bit last);
    mem[at/4 + 0] = 32'(bufa);
    mem[at/4 + 1] = 32'h0;
    mem[at/4 + 2] = 32'(nxt);
    mem[at/4 + 3] = last ? 32'h8000_0000 : 32'h0;
    mem[at/4 + 4] = {16'hABCD, 16'(cnt)};
    mem[at/4 + 5] = cfg;
    mem[at/4 + 6] = 32'h0;
    mem[at/4 + 7] = 32'h0;
    if (cfg[31])
      for (int i = 0; i < cnt; i++)
        exp_q.push_back({cfg[5], cfg[4], (i == 0) & cfg[1], (i == cnt-1) & cfg[0], pat(bufa + i)});
  endtask

  task automatic wr_reg(input int kind, input logic [31:0] d);
    @(negedge clk);
    reg_wdata = d;
    ptr_lo_we = (kind == 0);
    ptr_hi_we = (kind == 1);
    ctl_we    = (kind == 2);
    @(negedge clk);
    ptr_lo_we = 0; ptr_hi_we = 0; ctl_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && q_valid; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // memory model and stream monitor
  initial begin
    bit tog = 0, pend = 0, hold = 0, ack;
    logic [ADDR_W-1:0] pend_addr = '0;
    logic [7:0] hold_data = '0;
    int rc = 0;
    logic [11:0] e, got;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pend && (!mem_req || mem_addr != pend_addr)) r12_bad++;
        ack = mem_req && (!stall_mode || tog);
        tog = !tog;
        pend = mem_req && !ack;
        pend_addr = mem_addr;
        mem_ack = ack;
        if (ack) begin
          if (mem_we) begin
            mem[mem_addr[9:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem[mem_addr[9:2]];
            rd_cnt++;
            if (mem_addr < 16'h200) last_desc_rd = int'(mem_addr);
          end
        end
        if (hold && (!tx_valid || tx_data != hold_data)) r7_bad++;
        rc++;
        tx_ready = rdy_mode ? ((rc % 3) != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
          beats++;
          got = {tx_crc, tx_pad, tx_sof, tx_eof, tx_data};
          if (exp_q.size() == 0) chk(0, "R5 unexpected byte", got, 0);
          else begin
            e = exp_q.pop_front();
            chk(got[7:0] == e[7:0], "R5 byte value", got[7:0], e[7:0]);
            chk(got[11:8] == e[11:8], "R6 crc/pad/sof/eof flags", got[11:8], e[11:8]);
          end
        end
        hold = tx_valid && !tx_ready;
        hold_data = tx_data;
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!q_valid, "R1 q_valid after reset", q_valid, 0);
    chk(!eoq, "R1 eoq after reset", eoq, 0);
    chk(!mem_req, "R1 mem_req after reset", mem_req, 0);
    chk(!tx_valid, "R1 tx_valid after reset", tx_valid, 0);

    // chain: A (unaligned buffer) -> B (zero length) -> C (last)
    build_desc(32'h100, 32'h203, 9, 32'h8000_0023, 32'h140, 0);
    build_desc(32'h140, 32'h280, 0, 32'h8000_0003, 32'h160, 0);
    build_desc(32'h160, 32'h2C1, 6, 32'h8105_0012, 32'h000, 1);

    wr_reg(2, 32'h0);
    wr_reg(0, 32'h105);
    wr_reg(1, 32'h0000_0000);
    chk(!q_valid, "R2 high write without bit31", q_valid, 0);
    wr_reg(1, 32'h8000_0000);
    chk(q_valid, "R2 high write with bit31", q_valid, 1);
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R2 no fetch while go clear", rd_cnt, 0);
    rdy_mode = 1;
    wr_reg(2, 32'h0000_8001);
    wr_reg(0, 32'h180);               // busy: must be ignored (R11)
    wait_idle();
    chk(beats == 15, "R5 total bytes over chain", beats, 15);
    chk(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);
    chk(mem[32'h114/4] == expect_wb(32'h8000_0023), "R8 writeback A", mem[32'h114/4], expect_wb(32'h8000_0023));
    chk(mem[32'h154/4] == expect_wb(32'h8000_0003), "R10 writeback zero-length B", mem[32'h154/4], expect_wb(32'h8000_0003));
    chk(mem[32'h174/4] == expect_wb(32'h8105_0012), "R8 writeback C flags cleared", mem[32'h174/4], expect_wb(32'h8105_0012));
    chk(wr_cnt == 3, "R9 one write per descriptor", wr_cnt, 3);
    chk(!q_valid, "R9 valid cleared at chain end", q_valid, 0);
    chk(!eoq, "R9 no eoq on normal end", eoq, 0);

    // re-arm: old pointer kept, descriptor A no longer owned
    wr_reg(1, 32'h8000_0000);
    wait_idle();
    chk(eoq, "R4 eoq on unowned descriptor", eoq, 1);
    chk(!q_valid, "R4 valid cleared on unowned", q_valid, 0);
    chk(wr_cnt == 3, "R4 no writeback on unowned", wr_cnt, 3);
    chk(beats == 15, "R4 no bytes on unowned", beats, 15);
    chk(last_desc_rd == 32'h114, "R11 R3 fetch used old pointer", last_desc_rd, 32'h114);

    // stalled memory and stalled consumer, new pointer
    stall_mode = 1;
    build_desc(32'h180, 32'h301, 7, 32'h8000_0021, 32'h0, 1);
    wr_reg(0, 32'h180);
    wr_reg(1, 32'h8000_0000);
    chk(!eoq, "R4 eoq cleared on re-arm", eoq, 0);
    wait_idle();
    chk(beats == 22, "R5 bytes with stalls", beats, 22);
    chk(exp_q.size() == 0, "R6 stream drained", exp_q.size(), 0);
    chk(mem[32'h194/4] == expect_wb(32'h8000_0021), "R8 writeback D", mem[32'h194/4], expect_wb(32'h8000_0021));
    chk(!q_valid, "R9 valid cleared after D", q_valid, 0);
    chk(r7_bad == 0, "R7 stream held while not ready", r7_bad, 0);
    chk(r12_bad == 0, "R12 request held until ack", r12_bad, 0);
    summary();
  end
endmodule